// File: doc/BRIEF.md
# Dual-Context Page Translation Table

This block turns an 18-bit virtual word address into a physical address through one of two direct-mapped translation tables, one serving executive mode and one serving user mode. Each table holds one expanded entry per virtual page. When paging is switched off, a hardwired identity map takes the place of both tables. Every request runs through a small controller. If the selected entry cannot serve the access, the controller asks an external page walker for the entry, writes the answer into the table and retries the lookup.

A request names the address, whether it is a write, and whether it uses the current or the previous context. Table choice follows the processor mode and a user-I/O flag. Addresses below the accumulator count are never translated; they are reported as register accesses. A clear command drops one page from both tables. A flush empties both tables at once.

Controller states: `ST_IDLE` waits for a request (IDLE→LOOK on `req_valid`). `ST_LOOK` reads the selected entry (LOOK→DONE on a register access or a usable entry, LOOK→WAIT when a fill is needed). `ST_WAIT` holds the fill request (WAIT→APPLY when the walker answers with an entry, WAIT→DONE when it reports a failure). `ST_APPLY` is the cycle in which the new entry becomes visible (APPLY→LOOK, always). `ST_DONE` presents the result for one cycle (DONE→IDLE, always).

Top module: `xlate_table`

## Requirements
- R1: After reset both tables are empty, `req_ready` is 1, `resp_valid` and `fill_req` are 0 and `nxm_seen` is 0.
- R2: An entry is EW = PPN_W+2 bits wide: bit EW-1 is the write permit, bit EW-2 is the valid bit, bits PPN_W-1:0 hold the frame number; an all-zero entry is invalid. `resp_kind` encodes 0 = memory, 1 = register access, 2 = page fail, 3 = nonexistent memory.
- R3: A read asks for a fill only when its entry is all zero; a valid read-only entry serves a read with no fill.
- R4: A write asks for a fill whenever the entry's write permit is clear, including on a valid read-only entry.
- R5: The physical address is the entry's frame number concatenated above the low OFF_W bits of the virtual address.
- R6: With `paging_en` low every lookup uses the identity map (page i to frame i, always valid and writable) and never asks for a fill.
- R7: A `flush` pulse empties both tables, so later accesses to any page ask for a fill again.
- R8: A `clr_valid` pulse zeroes the entry of page `clr_vpn` in both the executive and the user table.
- R9: In user mode both contexts use the user table; in executive mode the current context uses the executive table and the previous context uses the user table only when `uio_flag` is 1. `fill_user` names the table being filled.
- R10: An address below AC_NUM completes with kind 1 and the address itself as `resp_pa`, with no fill.
- R11: A frame number at or above MEM_PAGES completes with kind 3 and sets the sticky `nxm_seen` output.
- R12: A fill answer lands in the table at the clock edge that accepts it, and the lookup is retried after one more cycle; a failed fill completes with kind 2. `fill_req` holds, with a stable address, until answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_en | input | 1 | 1 = translate through the tables, 0 = identity map |
| user_mode | input | 1 | Processor is in user mode |
| uio_flag | input | 1 | Previous context of executive mode uses the user table |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is 1 |
| req_ready | output | 1 | Controller is idle |
| req_va | input | VA_W | Virtual address |
| req_wr | input | 1 | 1 = write access |
| req_prev | input | 1 | 1 = previous context |
| resp_valid | output | 1 | Result is valid for one cycle |
| resp_kind | output | 2 | Result kind (see R2) |
| resp_pa | output | PA_W | Physical address |
| fill_req | output | 1 | Entry needed from the walker |
| fill_va | output | VA_W | Address being filled |
| fill_wr | output | 1 | Fill is for a write |
| fill_user | output | 1 | Fill targets the user table |
| fill_valid | input | 1 | Walker answer strobe |
| fill_fail | input | 1 | Walker found the access illegal |
| fill_entry | input | EW | Entry supplied by the walker |
| clr_valid | input | 1 | Clear one page in both tables |
| clr_vpn | input | VPN_W | Page to clear |
| flush | input | 1 | Empty both tables |
| nxm_seen | output | 1 | Sticky nonexistent-memory flag |

## Verification
The bench builds the block with MEM_PAGES set to 384 and the other parameters at their defaults. A frame limit below the 512 pages of the identity map lets an unpaged access fault as nonexistent memory, and it lets a walker-supplied frame land on either side of the limit. A bench walker answers fills from its own entry list, so read-only, read-write and refused pages, in both tables, can be exercised with the fill count of every request checked.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    typedef enum logic [1:0] {
        K_MEM   = 2'd0,
        K_ACC   = 2'd1,
        K_PFAIL = 2'd2,
        K_NXM   = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        SEL_EXEC  = 2'd0,
        SEL_USER  = 2'd1,
        SEL_IDENT = 2'd2
    } sel_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_APPLY = 3'd3,
        ST_DONE  = 3'd4
    } state_t;
endpackage

// File: rtl/xlate_store.sv
module xlate_store #(
    parameter int VPN_W = 9,
    parameter int EW    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             clr_en,
    input  logic [VPN_W-1:0] clr_vpn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [EW-1:0]    wr_data,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic [EW-1:0]    rd_data
);
    localparam int PAGES = 1 << VPN_W;

    logic [EW-1:0] tab [PAGES];
    logic          flush_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) tab[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < PAGES; i++) tab[i] <= '0;
        end else begin
            if (wr_en) tab[wr_vpn] <= wr_data;
            if (clr_en) tab[clr_vpn] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_d <= 1'b0;
        else        flush_d <= flush;
    end

    assign rd_data = tab[rd_vpn];

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_d && !wr_en && !flush) |-> (rd_data == '0)); // R7
endmodule

// File: rtl/xlate_ctl.sv
module xlate_ctl
    import xlate_pkg::*;
#(
    parameter int VA_W      = 18,
    parameter int OFF_W     = 9,
    parameter int PPN_W     = 11,
    parameter int MEM_PAGES = 1024,
    parameter int AC_NUM    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   paging_en,
    input  logic                   user_mode,
    input  logic                   uio_flag,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_va,
    input  logic                   req_wr,
    input  logic                   req_prev,
    output logic                   resp_valid,
    output logic [1:0]             resp_kind,
    output logic [PPN_W+OFF_W-1:0] resp_pa,
    output logic                   fill_req,
    output logic [VA_W-1:0]        fill_va,
    output logic                   fill_wr,
    output logic                   fill_user,
    input  logic                   fill_valid,
    input  logic                   fill_fail,
    input  logic [PPN_W+1:0]       fill_entry,
    output logic [VA_W-OFF_W-1:0]  rd_vpn,
    input  logic [PPN_W+1:0]       ex_rd_data,
    input  logic [PPN_W+1:0]       us_rd_data,
    output logic                   ex_wr_en,
    output logic                   us_wr_en,
    output logic [PPN_W+1:0]       wr_data,
    output logic                   nxm_seen
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int EW    = PPN_W + 2;

    state_t            state_q, state_d;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    sel_t              sel_q, sel_now;
    kind_t             kind_q;
    logic [PA_W-1:0]   pa_q;
    logic [EW-1:0]     entry;
    logic [PPN_W-1:0]  ent_ppn;
    logic              need_fill, is_ac, out_of_mem;
    logic [PA_W-1:0]   look_pa;

    // Table choice from mode, context and user-I/O flag
    always_comb begin
        if (!paging_en)               sel_now = SEL_IDENT;
        else if (user_mode)           sel_now = SEL_USER;
        else if (req_prev && uio_flag) sel_now = SEL_USER;
        else                          sel_now = SEL_EXEC;
    end

    assign rd_vpn = va_q[VA_W-1:OFF_W];

    always_comb begin
        unique case (sel_q)
            SEL_EXEC:  entry = ex_rd_data;
            SEL_USER:  entry = us_rd_data;
            SEL_IDENT: entry = {2'b11, PPN_W'(rd_vpn)};
            default:   entry = '0;
        endcase
    end

    assign ent_ppn    = entry[PPN_W-1:0];
    assign need_fill  = wr_q ? !entry[EW-1] : (entry == '0);
    assign is_ac      = va_q < VA_W'(AC_NUM);
    assign look_pa    = {ent_ppn, va_q[OFF_W-1:0]};
    assign out_of_mem = {1'b0, ent_ppn} >= (PPN_W+1)'(MEM_PAGES);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_LOOK;
            ST_LOOK:  state_d = (!is_ac && need_fill) ? ST_WAIT : ST_DONE;
            ST_WAIT:  if (fill_valid) state_d = fill_fail ? ST_DONE : ST_APPLY;
            ST_APPLY: state_d = ST_LOOK;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            wr_q     <= 1'b0;
            sel_q    <= SEL_EXEC;
            kind_q   <= K_MEM;
            pa_q     <= '0;
            nxm_seen <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q  <= req_va;
                wr_q  <= req_wr;
                sel_q <= sel_now;
            end
            if (state_q == ST_LOOK) begin
                if (is_ac) begin
                    kind_q <= K_ACC;
                    pa_q   <= PA_W'(va_q);
                end else if (!need_fill) begin
                    kind_q <= out_of_mem ? K_NXM : K_MEM;
                    pa_q   <= look_pa;
                    if (out_of_mem) nxm_seen <= 1'b1;
                end
            end
            if (state_q == ST_WAIT && fill_valid && fill_fail) begin
                kind_q <= K_PFAIL;
                pa_q   <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_DONE);
        resp_kind  = kind_q;
        resp_pa    = pa_q;
        fill_req   = (state_q == ST_WAIT);
        fill_va    = va_q;
        fill_wr    = wr_q;
        fill_user  = (sel_q == SEL_USER);
        wr_data    = fill_entry;
        ex_wr_en   = (state_q == ST_WAIT) && fill_valid && !fill_fail && (sel_q == SEL_EXEC);
        us_wr_en   = (state_q == ST_WAIT) && fill_valid && !fill_fail && (sel_q == SEL_USER);
    end

    AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_va))); // R12
    AST_FILL_THEN_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid && !fill_fail) |=> (!resp_valid && !fill_req && !req_ready)); // R12
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready)); // R2
    AST_IDENT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (sel_q != SEL_IDENT)); // R6
    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == K_ACC) |-> (resp_pa < PA_W'(AC_NUM))); // R10
    AST_MEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == K_MEM) |-> ({1'b0, resp_pa[PA_W-1:OFF_W]} < (PPN_W+1)'(MEM_PAGES))); // R11
    AST_NXM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == K_NXM) |-> nxm_seen); // R11
endmodule

// File: rtl/xlate_table.sv
module xlate_table
    import xlate_pkg::*;
#(
    parameter int VA_W      = 18,
    parameter int OFF_W     = 9,
    parameter int PPN_W     = 11,
    parameter int MEM_PAGES = 1024,
    parameter int AC_NUM    = 16,
    localparam int VPN_W    = VA_W - OFF_W,
    localparam int PA_W     = PPN_W + OFF_W,
    localparam int EW       = PPN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             paging_en,
    input  logic             user_mode,
    input  logic             uio_flag,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_wr,
    input  logic             req_prev,
    output logic             resp_valid,
    output logic [1:0]       resp_kind,
    output logic [PA_W-1:0]  resp_pa,
    output logic             fill_req,
    output logic [VA_W-1:0]  fill_va,
    output logic             fill_wr,
    output logic             fill_user,
    input  logic             fill_valid,
    input  logic             fill_fail,
    input  logic [EW-1:0]    fill_entry,
    input  logic             clr_valid,
    input  logic [VPN_W-1:0] clr_vpn,
    input  logic             flush,
    output logic             nxm_seen
);
    logic [VPN_W-1:0] rd_vpn;
    logic [EW-1:0]    rd_data [2];
    logic [1:0]       wr_en;
    logic [EW-1:0]    wr_data;

    xlate_ctl #(
        .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
        .MEM_PAGES(MEM_PAGES), .AC_NUM(AC_NUM)
    ) ctl_i (
        .clk(clk), .rst_n(rst_n),
        .paging_en(paging_en), .user_mode(user_mode), .uio_flag(uio_flag),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_wr(req_wr), .req_prev(req_prev),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_pa(resp_pa),
        .fill_req(fill_req), .fill_va(fill_va), .fill_wr(fill_wr),
        .fill_user(fill_user), .fill_valid(fill_valid), .fill_fail(fill_fail),
        .fill_entry(fill_entry),
        .rd_vpn(rd_vpn), .ex_rd_data(rd_data[0]), .us_rd_data(rd_data[1]),
        .ex_wr_en(wr_en[0]), .us_wr_en(wr_en[1]), .wr_data(wr_data),
        .nxm_seen(nxm_seen)
    );

    // Index 0: executive table, index 1: user table
    for (genvar t = 0; t < 2; t++) begin : g_tab
        xlate_store #(.VPN_W(VPN_W), .EW(EW)) store_i (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .clr_en(clr_valid), .clr_vpn(clr_vpn),
            .wr_en(wr_en[t]), .wr_vpn(rd_vpn), .wr_data(wr_data),
            .rd_vpn(rd_vpn), .rd_data(rd_data[t])
        );
    end

    AST_ONE_TABLE_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_en) <= 1); // R9
endmodule

// File: tb/xlate_table_tb.sv
`timescale 1ns/1ps
module xlate_table_tb_top;
    localparam int VA_W = 18, OFF_W = 9, PPN_W = 11, MEMP = 384, ACN = 16;
    localparam int VPN_W = VA_W - OFF_W, PA_W = PPN_W + OFF_W, EW = PPN_W + 2;

    logic clk = 0, rst_n = 0;
    logic paging_en = 0, user_mode = 0, uio_flag = 0;
    logic req_valid = 0, req_wr = 0, req_prev = 0;
    logic [VA_W-1:0] req_va = '0;
    logic req_ready, resp_valid, fill_req, fill_wr, fill_user, nxm_seen;
    logic [1:0] resp_kind;
    logic [PA_W-1:0] resp_pa;
    logic [VA_W-1:0] fill_va;
    logic fill_valid = 0, fill_fail = 0;
    logic [EW-1:0] fill_entry = '0;
    logic clr_valid = 0, flush = 0;
    logic [VPN_W-1:0] clr_vpn = '0;

    always #4 clk = ~clk;

    xlate_table #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .MEM_PAGES(MEMP), .AC_NUM(ACN)) dut_i (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .user_mode(user_mode),
        .uio_flag(uio_flag), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_wr(req_wr), .req_prev(req_prev),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_pa(resp_pa),
        .fill_req(fill_req), .fill_va(fill_va), .fill_wr(fill_wr), .fill_user(fill_user),
        .fill_valid(fill_valid), .fill_fail(fill_fail), .fill_entry(fill_entry),
        .clr_valid(clr_valid), .clr_vpn(clr_vpn), .flush(flush), .nxm_seen(nxm_seen));

    typedef struct { int kind; int pa; int fills; string tag; } exp_t;
    exp_t exp_q[$];
    int total = 0, bad = 0, fill_cnt = 0;
    bit done = 0;
    logic [EW-1:0] walk_tab [2][512];
    logic [EW-1:0] mdl_tab  [2][512];

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [EW-1:0] ent(int w, int v, int ppn);
        return {w[0], v[0], PPN_W'(ppn)};
    endfunction

    // Walker: answers fills from walk_tab, refuses empty or write-to-read-only
    initial begin
        forever begin
            @(negedge clk);
            if (fill_valid) begin
                fill_valid = 0;
                fill_fail  = 0;
            end else if (fill_req) begin
                logic [EW-1:0] w;
                w = walk_tab[fill_user ? 1 : 0][fill_va[VA_W-1:OFF_W]];
                fill_cnt++;
                fill_entry = w;
                fill_fail  = (w == '0) || (fill_wr && !w[EW-1]);
                fill_valid = 1;
            end
        end
    end

    // Monitor: pops expected results as responses appear
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("unexpected response R2", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.tag, " kind"}, int'(resp_kind), e.kind);
                    check({e.tag, " pa"}, int'(resp_pa), e.pa);
                    check({e.tag, " fills"}, fill_cnt, e.fills);
                end
                fill_cnt = 0;
            end
        end
    end

    // Driver: computes the expected result from the model, then issues the request
    task automatic access(int va, bit wr, bit prv, string tag);
        exp_t e;
        int vpn, sel;
        logic [EW-1:0] en;
        vpn = va >> OFF_W;
        e.tag = tag; e.fills = 0;
        if (va < ACN) begin
            e.kind = 1; e.pa = va;
        end else begin
            if (!paging_en) begin
                sel = 2; en = ent(1, 1, vpn);
            end else begin
                sel = (user_mode || (prv && uio_flag)) ? 1 : 0;
                en = mdl_tab[sel][vpn];
            end
            e.kind = 0;
            if (wr ? !en[EW-1] : (en == '0)) begin
                logic [EW-1:0] w;
                w = walk_tab[sel][vpn];
                e.fills = 1;
                if (w == '0 || (wr && !w[EW-1])) e.kind = 2;
                else begin mdl_tab[sel][vpn] = w; en = w; end
            end
            if (e.kind == 2) e.pa = 0;
            else begin
                e.pa = (int'(en[PPN_W-1:0]) << OFF_W) | (va & ((1 << OFF_W) - 1));
                e.kind = (int'(en[PPN_W-1:0]) >= MEMP) ? 3 : 0;
            end
        end
        exp_q.push_back(e);
        while (!req_ready) @(negedge clk);
        req_va = VA_W'(va); req_wr = wr; req_prev = prv; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic clear_page(int vpn);
        clr_vpn = VPN_W'(vpn); clr_valid = 1;
        @(negedge clk);
        clr_valid = 0;
        mdl_tab[0][vpn] = '0; mdl_tab[1][vpn] = '0;
    endtask

    task automatic flush_all();
        flush = 1;
        @(negedge clk);
        flush = 0;
        for (int i = 0; i < 512; i++) begin mdl_tab[0][i] = '0; mdl_tab[1][i] = '0; end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            walk_tab[0][i] = '0; walk_tab[1][i] = '0;
            mdl_tab[0][i] = '0; mdl_tab[1][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ready", int'(req_ready), 1);
        check("R1 resp_valid", int'(resp_valid), 0);
        check("R1 fill_req", int'(fill_req), 0);
        check("R1 nxm_seen", int'(nxm_seen), 0);

        // Paging off: identity map
        access((5 << OFF_W) | 5, 0, 0, "R6 identity read");
        access((300 << OFF_W) | 9, 1, 0, "R6 identity write");
        access((450 << OFF_W) | 1, 1, 0, "R11 identity nxm");
        check("R11 nxm_seen", int'(nxm_seen), 1);
        access(7, 1, 0, "R10 register access");

        paging_en = 1;
        access(3, 0, 0, "R10 register access paged");
        walk_tab[0][20] = ent(0, 1, 100);
        access((20 << OFF_W) | 33, 0, 0, "R3 R12 read fill read-only");
        access((20 << OFF_W) | 34, 0, 0, "R3 read hits read-only");
        access((20 << OFF_W) | 35, 1, 0, "R4 R12 write on read-only refused");
        walk_tab[0][20] = ent(1, 1, 200);
        access((20 << OFF_W) | 36, 1, 0, "R4 R5 write fill read-write");
        access((20 << OFF_W) | 37, 1, 0, "R4 write hits read-write");

        user_mode = 1;
        walk_tab[1][20] = ent(1, 1, 50);
        access((20 << OFF_W) | 2, 0, 0, "R9 user table fill");
        access((20 << OFF_W) | 3, 0, 1, "R9 user previous context");
        user_mode = 0; uio_flag = 1;
        access((20 << OFF_W) | 4, 0, 1, "R9 exec previous with uio");
        uio_flag = 0;
        access((20 << OFF_W) | 5, 0, 1, "R9 exec previous without uio");

        clear_page(20);
        access((20 << OFF_W) | 6, 0, 0, "R8 exec refill after clear");
        user_mode = 1;
        access((20 << OFF_W) | 7, 0, 0, "R8 user refill after clear");
        user_mode = 0;

        walk_tab[0][40] = ent(1, 1, 500);
        access((40 << OFF_W) | 8, 0, 0, "R11 walker frame nxm");
        access((41 << OFF_W) | 8, 0, 0, "R12 empty walker entry page fail");

        flush_all();
        access((20 << OFF_W) | 9, 0, 0, "R7 exec refill after flush");
        user_mode = 1;
        access((20 << OFF_W) | 10, 0, 0, "R7 user refill after flush");
        user_mode = 0; paging_en = 0;
        access((100 << OFF_W) | 11, 0, 0, "R6 identity after flush");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule